// File: doc/BRIEF.md
# Drift-Compensated Precision Time Counter

This block keeps a free-running time-of-day value for precision time protocol work. It runs on a reference clock. A fractional accumulator is loaded by adding a programmable addend on every enabled reference cycle. Each carry-out of that accumulator is a tick, and on each tick the raw time counter grows by a programmable nominal period in nanoseconds. Software trims the addend to make up for drift in the reference oscillator. A bypass mode skips the accumulator and makes every enabled cycle a tick.

The reported time is the raw counter plus a programmable offset. The offset never writes back into the raw counter. A prescaler counts ticks and flips an internal divided state every N ticks. That state drives a divided clock output, and a phase-select input can invert it. An enable input freezes all run state while it is low. A soft reset clears the run state. It leaves the configuration alone, because the configuration arrives as inputs that the block never changes.

Top module: `ptp_time_counter`

## Requirements
- R1: When bypass is 0, every enabled cycle adds the addend to the 32-bit accumulator, modulo 2^32. The raw counter grows by the period in the cycle after a carry-out, and only then.
- R2: When bypass is 1, the raw counter grows by the period after every enabled cycle, whatever the accumulator does.
- R3: While enable is 0 and soft reset is 0, the raw counter, the accumulator, the prescaler and the divided state all hold their values.
- R4: Soft reset takes priority over enable. It clears the raw counter, the accumulator, the prescaler and the divided state on the next edge. Once it is released, counting resumes with the unchanged addend, period and prescale.
- R5: timeNow equals rawCount plus offset, modulo 2^CNT_W, in the same cycle. The offset never alters rawCount.
- R6: The divided state inverts on every N-th tick, where N is the prescale value. A prescale of 0 acts as 1.
- R7: divClk equals the divided state when outPhase is 0, and its inverse when outPhase is 1.
- R8: While rstN is low, rawCount is 0, timeNow equals offset and divClk equals outPhase.
- R9: The raw counter wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable |
| softReset | input | 1 | Synchronous clear of the run state |
| bypass | input | 1 | Makes every enabled cycle a tick |
| outPhase | input | 1 | Inverts the divided clock output |
| addend | input | ACC_W | Frequency-tuning addend |
| period | input | PER_W | Nanoseconds added per tick |
| prescale | input | PSC_W | Ticks per divided-state toggle (0 acts as 1) |
| offset | input | CNT_W | Added to the raw counter for the reported time |
| rawCount | output | CNT_W | Raw time counter |
| timeNow | output | CNT_W | Raw counter plus offset |
| divClk | output | 1 | Divided clock output |

## Verification
The bench builds the block with CNT_W=16 and PSC_W=4, and keeps the 32-bit accumulator and the 8-bit period. With a 16-bit counter, a bypassed run at a large period wraps the counter within a few hundred cycles, so R9 and the modulo sum of R5 come within reach. With a 4-bit prescaler, the widest prescale value and the 0-as-1 case can both be exercised in a short run.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef struct packed {
    logic cntStep;    // raw counter adds period
    logic divToggle;  // divided state inverts
    logic clear;      // synchronous clear of run state
  } ptp_strobe_t;
endpackage

// File: rtl/ptp_ctrl.sv
module ptp_ctrl
  import ptp_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             softReset,
  input  logic             bypass,
  input  logic [ACC_W-1:0] addend,
  input  logic [PSC_W-1:0] prescale,
  output ptp_strobe_t      strobes
);
  logic [ACC_W-1:0] accQ;
  logic [ACC_W:0]   accSum;
  logic [PSC_W-1:0] pscQ;
  logic [PSC_W-1:0] nEff;
  logic             tick;
  logic             run;
  logic             pscWrap;

  assign accSum  = {1'b0, accQ} + {1'b0, addend};
  assign tick    = bypass | accSum[ACC_W];
  assign run     = enable & ~softReset;
  assign nEff    = (prescale == '0) ? PSC_W'(1) : prescale;
  assign pscWrap = ({1'b0, pscQ} + (PSC_W+1)'(1)) >= {1'b0, nEff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      pscQ <= '0;
    end else if (softReset) begin
      accQ <= '0;
      pscQ <= '0;
    end else if (enable) begin
      accQ <= accSum[ACC_W-1:0];
      if (tick) pscQ <= pscWrap ? '0 : pscQ + PSC_W'(1);
    end
  end

  always_comb begin
    strobes.cntStep   = run & tick;
    strobes.divToggle = run & tick & pscWrap;
    strobes.clear     = softReset;
  end

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !softReset) |=> ($stable(accQ) && $stable(pscQ)));
  p_clear_state_r4: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (accQ == '0 && pscQ == '0));
  p_bypass_every_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && enable && !softReset) |-> strobes.cntStep);
  p_acc_advance_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !softReset) |=> accQ == ($past(accQ) + $past(addend)));
endmodule

// File: rtl/ptp_datapath.sv
module ptp_datapath
  import ptp_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptp_strobe_t      strobes,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] offset,
  input  logic             outPhase,
  output logic [CNT_W-1:0] rawCount,
  output logic [CNT_W-1:0] timeNow,
  output logic             divClk
);
  logic [CNT_W-1:0] rawQ;
  logic             divQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= '0;
      divQ <= 1'b0;
    end else if (strobes.clear) begin
      rawQ <= '0;
      divQ <= 1'b0;
    end else begin
      if (strobes.cntStep)   rawQ <= rawQ + CNT_W'(period);
      if (strobes.divToggle) divQ <= ~divQ;
    end
  end

  assign rawCount = rawQ;
  assign timeNow  = rawQ + offset;
  assign divClk   = divQ ^ outPhase;

  p_step_by_period_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntStep && !strobes.clear) |=> rawCount == $past(rawCount) + CNT_W'($past(period)));
  p_no_step_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntStep && !strobes.clear) |=> $stable(rawCount));
  p_clear_raw_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> rawCount == '0);
  p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.divToggle && !strobes.clear) |=> divQ != $past(divQ));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int ACC_W = 32,
  parameter int PER_W = 8,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             softReset,
  input  logic             bypass,
  input  logic             outPhase,
  input  logic [ACC_W-1:0] addend,
  input  logic [PER_W-1:0] period,
  input  logic [PSC_W-1:0] prescale,
  input  logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] rawCount,
  output logic [CNT_W-1:0] timeNow,
  output logic             divClk
);
  ptp_strobe_t strobes;

  ptp_ctrl #(.ACC_W(ACC_W), .PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .softReset(softReset),
    .bypass(bypass), .addend(addend), .prescale(prescale), .strobes(strobes)
  );

  ptp_datapath #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .period(period),
    .offset(offset), .outPhase(outPhase), .rawCount(rawCount),
    .timeNow(timeNow), .divClk(divClk)
  );
endmodule

// File: tb/ptp_time_counter_bench.sv
`timescale 1ns/1ps
module ptp_time_counter_bench;
  localparam int CNT_W = 16;
  localparam int ACC_W = 32;
  localparam int PER_W = 8;
  localparam int PSC_W = 4;
  localparam longint unsigned CMASK = (64'd1 << CNT_W) - 1;
  localparam longint unsigned AMASK = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, softReset = 1'b0, bypass = 1'b0, outPhase = 1'b0;
  logic [ACC_W-1:0] addend = '0;
  logic [PER_W-1:0] period = '0;
  logic [PSC_W-1:0] prescale = '0;
  logic [CNT_W-1:0] offset = '0;
  logic [CNT_W-1:0] rawCount, timeNow;
  logic divClk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  longint unsigned mAcc = 0, mRaw = 0, mPsc = 0;
  bit mDiv = 0, mWrapped = 0;

  always #4 clk = ~clk;

  ptp_time_counter #(.CNT_W(CNT_W), .ACC_W(ACC_W), .PER_W(PER_W), .PSC_W(PSC_W)) u_ptp_time_counter (
    .clk(clk), .rstN(rstN), .enable(enable), .softReset(softReset), .bypass(bypass),
    .outPhase(outPhase), .addend(addend), .period(period), .prescale(prescale),
    .offset(offset), .rawCount(rawCount), .timeNow(timeNow), .divClk(divClk)
  );

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mRaw = 0; mPsc = 0; mDiv = 0; mWrapped = 0;
    end else begin
      mWrapped = 0;
      if (softReset) begin
        mAcc = 0; mRaw = 0; mPsc = 0; mDiv = 0;
      end else if (enable) begin
        longint unsigned sum;
        longint unsigned n;
        bit tk;
        sum = mAcc + longint'(addend);
        tk = bypass || ((sum >> ACC_W) != 0);
        mAcc = sum & AMASK;
        if (tk) begin
          n = (prescale == 0) ? 1 : longint'(prescale);
          mWrapped = (mRaw + longint'(period)) > CMASK;
          mRaw = (mRaw + longint'(period)) & CMASK;
          if (mPsc + 1 >= n) begin mPsc = 0; mDiv = ~mDiv; end
          else mPsc = mPsc + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison at the falling edge
  task automatic cmpCycle();
    if (!rstN) begin
      chk("R8 raw", rawCount, 0);
      chk("R8 time", timeNow, offset);
      chk("R8 div", divClk, outPhase);
    end else begin
      chk(mWrapped ? "R9 raw" : (bypass ? "R2 raw" : "R1 raw"), rawCount, mRaw);
      chk("R5 time", timeNow, (mRaw + longint'(offset)) & CMASK);
      chk("R6/R7 div", divClk, mDiv ^ outPhase);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      cmpCycle();
    end
  endtask

  initial begin
    logic [CNT_W-1:0] held;
    bit held2;
    logic [31:0] lcg;
    offset = 16'h1234; outPhase = 1'b1;
    run(3);                          // R8 during reset
    rstN = 1'b1;
    run(1);
    chk("R8 raw after release", rawCount, 0);

    // R1: carry every fourth cycle
    addend = 32'h4000_0000; period = 8'd8; prescale = 4'd2; outPhase = 1'b0; enable = 1'b1;
    run(40);
    chk("R1 raw after 40 cycles", rawCount, 16'd80);

    // R6: prescale 0 acts as 1, near-every-cycle carries
    addend = 32'hFFFF_FFFF; period = 8'd5; prescale = 4'd0;
    run(25);
    prescale = 4'd15;
    run(60);

    // R2: bypass
    bypass = 1'b1; period = 8'd3; addend = 32'd0; prescale = 4'd3;
    run(30);

    // R3: enable low holds everything
    enable = 1'b0;
    run(1);
    held = rawCount; held2 = divClk;
    run(10);
    chk("R3 raw held", rawCount, held);
    chk("R3 div held", divClk, held2);
    enable = 1'b1;
    run(5);

    // R5 / R7: offset and phase changes
    offset = 16'hFFF0; outPhase = 1'b1;
    run(10);
    offset = 16'h0001; outPhase = 1'b0;
    run(5);

    // R4: soft reset while disabled and while enabled
    enable = 1'b0; softReset = 1'b1;
    run(1);
    chk("R4 raw cleared (disabled)", rawCount, 0);
    softReset = 1'b0; enable = 1'b1; bypass = 1'b0; addend = 32'h8000_0000; period = 8'd10;
    run(12);
    softReset = 1'b1;
    run(2);
    chk("R4 raw cleared (enabled)", rawCount, 0);
    chk("R4 div cleared", divClk, outPhase);
    softReset = 1'b0;
    run(4);
    chk("R4 resumes with kept addend", rawCount, 16'd20);

    // R9: wrap with bypass and large period
    bypass = 1'b1; period = 8'd255; prescale = 4'd7;
    run(300);

    // mixed addends
    bypass = 1'b0; lcg = 32'h1357_9BDF;
    for (int k = 0; k < 40; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      addend = lcg; period = lcg[7:0]; prescale = lcg[11:8];
      bypass = lcg[20]; outPhase = lcg[21];
      run(5);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule